// File: doc/BRIEF.md
# Crypto Engine Interrupt Status Unit

This unit gathers the completion and fault events of a crypto accelerator and exposes them to a processor. Five one-cycle event pulses come in: input transfer finished, result ready, transfer bus fault, key-store write fault and key-store read fault. Each pulse sets a sticky flag. Software reads the flags through a small word-addressed register bus, acknowledges them with a write-one-to-clear register, and can wipe all state with a software-reset write.

Only the two completion flags can reach the single level-type interrupt line, and only when their enable bits are set. The three fault flags never raise the interrupt. They appear only in the raw status word, so software has to poll for them after a completion interrupt, or on a timer.

Register map, by word address: 0 enable (read/write), 1 raw status (read-only), 2 masked status (read-only), 3 clear (write-only), 4 software reset (write-only). Bus reads are registered: data appears one clock after the read strobe.

Top module: `crypto_irq_status`

## Requirements
- R1: After `rst_n` is low at a clock edge, all flags and enable bits are zero, `irq` is low and `bus_rdata` is zero.
- R2: Flag bit positions are: 0 input transfer done, 1 result ready, 2 bus fault, 3 key write fault, 4 key read fault. An `evt` pulse on a bit sets that flag at the same edge. The flag stays set until it is cleared or reset.
- R3: Writing address 3 clears each flag whose `bus_wdata` bit is one. Flags whose bits are written as zero keep their value.
- R4: When an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R5: Address 0 stores enable bits 1:0 from `bus_wdata` and reads them back. Bits 4:2 are not stored and read as zero.
- R6: A read of address 2 returns the enable bits ANDed with the raw flags, so fault bits always read zero there.
- R7: `irq` is high exactly while an enabled completion flag (bit 0 or 1) is set. Fault flags never drive it.
- R8: Any write to address 4 clears all flags and the enable register at that edge, even when an event arrives in the same cycle.
- R9: A read strobe at an edge loads `bus_rdata` with the addressed register's value from before that edge. Addresses 3, 4 and all unmapped addresses read zero. Without a strobe, `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt | input | 5 | One-cycle event pulses, bit order as in R2 |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Flag, enable and software-reset effects all land at the edge that samples the stimulus. `irq` is derived from registers without a further flop, so the bench checks it one time unit after that edge. Read data is due one edge after the strobe. The driver therefore queues each expected word when it issues the read, and the monitor pops and compares it at the following falling edge. Expected values come from a bench-side model of the flags and enables, updated from the requirements after each stimulus cycle.

// File: rtl/cis_pkg.sv
// Shared constants for the crypto interrupt status unit.
// Assumes five flags, of which the lowest two are routable to the interrupt.
package cis_pkg;
    localparam int FLAG_W   = 5;
    localparam int ROUTED_W = 2;
    // flag bit positions
    localparam int FLG_IN_DONE = 0;
    localparam int FLG_RESULT  = 1;
    localparam int FLG_BUS_ERR = 2;
    localparam int FLG_KWR_ERR = 3;
    localparam int FLG_KRD_ERR = 4;
    // word addresses
    localparam int ADR_ENABLE = 0;
    localparam int ADR_RAW    = 1;
    localparam int ADR_MASKED = 2;
    localparam int ADR_CLEAR  = 3;
    localparam int ADR_SWRST  = 4;
endpackage

// File: rtl/cis_flag_bank.sv
// Sticky event flags: an event sets a flag, a clear-mask bit drops it,
// and the event wins a same-cycle conflict. Software reset clears all flags.
// Assumes event pulses are synchronous to clk.
module cis_flag_bank
    import cis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] evt,
    input  logic [FLAG_W-1:0] clr_mask,
    input  logic              sw_rst,
    output logic [FLAG_W-1:0] flags
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        // Purpose: hold one sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n || sw_rst)
                flags[i] <= 1'b0;
            else if (evt[i])
                flags[i] <= 1'b1;
            else if (clr_mask[i])
                flags[i] <= 1'b0;
        end
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst |=> ((flags & $past(evt)) == $past(evt)));                       // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst |=> ((flags & $past(clr_mask & ~evt)) == '0));                   // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst |=> ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask))); // R2
    AST_SWRST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (flags == '0));                                               // R8
endmodule

// File: rtl/cis_enable_gate.sv
// Enable register for the routed flags, masked status and the level interrupt.
// Assumes the routed flags are the lowest ROUTED_W bits of the flag vector.
module cis_enable_gate
    import cis_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_wr,
    input  logic [ROUTED_W-1:0] en_wdata,
    input  logic                sw_rst,
    input  logic [FLAG_W-1:0]   flags,
    output logic [ROUTED_W-1:0] en_q,
    output logic [FLAG_W-1:0]   masked,
    output logic                irq
);
    localparam int ERR_W = FLAG_W - ROUTED_W;

    // Purpose: hold enable bits for the routed flags.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)
            en_q <= '0;
        else if (en_wr)
            en_q <= en_wdata;
    end

    // Purpose: build masked status; fault bits can never be enabled.
    always_comb begin
        masked = {{ERR_W{1'b0}}, en_q & flags[ROUTED_W-1:0]};
        irq    = |masked;
    end

    AST_IRQ_ROUTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags[ROUTED_W-1:0]));                                         // R7
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !sw_rst) |=> (en_q == $past(en_wdata)));                       // R5
    AST_SWRST_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (en_q == '0 && !irq));                                        // R8
endmodule

// File: rtl/cis_reg_decode.sv
// Register-bus decode: write strobes for enable, clear and software reset,
// and a registered read mux. Assumes ADDR_W >= 3.
module cis_reg_decode
    import cis_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [ROUTED_W-1:0] en_q,
    input  logic [FLAG_W-1:0]   raw,
    input  logic [FLAG_W-1:0]   masked,
    output logic                en_wr,
    output logic                clr_wr,
    output logic                sw_rst,
    output logic [DATA_W-1:0]   rdata
);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ADR_ENABLE);
    localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(ADR_RAW);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(ADR_MASKED);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADR_CLEAR);
    localparam logic [ADDR_W-1:0] A_SWR = ADDR_W'(ADR_SWRST);

    logic [DATA_W-1:0] rd_mux;

    // Purpose: decode write strobes.
    always_comb begin
        en_wr  = wr_en && (addr == A_EN);
        clr_wr = wr_en && (addr == A_CLR);
        sw_rst = wr_en && (addr == A_SWR);
    end

    // Purpose: select read value; write-only and unmapped addresses give zero.
    always_comb begin
        rd_mux = '0;
        if (addr == A_EN)
            rd_mux[ROUTED_W-1:0] = en_q;
        else if (addr == A_RAW)
            rd_mux[FLAG_W-1:0] = raw;
        else if (addr == A_MSK)
            rd_mux[FLAG_W-1:0] = masked;
    end

    // Purpose: register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));                                              // R9
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_CLR || addr == A_SWR)) |=> (rdata == '0));          // R9
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_wr, clr_wr, sw_rst}));                                      // R8
endmodule

// File: rtl/crypto_irq_status.sv
// Top of the crypto interrupt status unit: sticky flags, enables, masked
// status and one level interrupt behind a word-addressed register bus.
// Assumes single-cycle event pulses and a synchronous active-low reset.
module crypto_irq_status
    import cis_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        evt,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [FLAG_W-1:0]   flags;
    logic [FLAG_W-1:0]   masked;
    logic [FLAG_W-1:0]   clr_mask;
    logic [ROUTED_W-1:0] en_q;
    logic                en_wr;
    logic                clr_wr;
    logic                sw_rst;
    logic                unused_wdata_hi;

    // Purpose: gate write data into a clear mask only on clear writes.
    always_comb begin
        clr_mask        = clr_wr ? bus_wdata[FLAG_W-1:0] : '0;
        unused_wdata_hi = ^bus_wdata[DATA_W-1:FLAG_W];
    end

    cis_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr_en),
        .rd_en  (bus_rd_en),
        .addr   (bus_addr),
        .en_q   (en_q),
        .raw    (flags),
        .masked (masked),
        .en_wr  (en_wr),
        .clr_wr (clr_wr),
        .sw_rst (sw_rst),
        .rdata  (bus_rdata)
    );

    cis_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_mask (clr_mask),
        .sw_rst   (sw_rst),
        .flags    (flags)
    );

    cis_enable_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (bus_wdata[ROUTED_W-1:0]),
        .sw_rst   (sw_rst),
        .flags    (flags),
        .en_q     (en_q),
        .masked   (masked),
        .irq      (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq && bus_rdata == '0));                                   // R1
endmodule

// File: tb/crypto_irq_status_tb_top.sv
module crypto_irq_status_tb_top;
    localparam int AW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    evt = '0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    always #10 clk = ~clk;   // 50 MHz

    crypto_irq_status #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // bench model, updated from the requirements
    logic [4:0] m_flags = '0;
    logic [1:0] m_en    = '0;

    // scoreboard
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    bit            pend = 0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one stimulus cycle; inputs driven at the falling edge, released after the rising edge
    task automatic cyc(input logic [4:0] e, input bit wr, input bit rd,
                       input int a, input logic [DW-1:0] wd, input string tag);
        logic [DW-1:0] exp;
        @(negedge clk);
        evt = e; bus_wr_en = wr; bus_rd_en = rd; bus_addr = AW'(a); bus_wdata = wd;
        if (rd) begin
            case (a)
                0: exp = DW'(m_en);
                1: exp = DW'(m_flags);
                2: exp = DW'(m_flags & {3'b000, m_en});
                default: exp = '0;
            endcase
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        if (wr && a == 4) begin
            m_flags = '0; m_en = '0;
        end else begin
            m_flags = (m_flags & ~((wr && a == 3) ? wd[4:0] : 5'b0)) | e;
            if (wr && a == 0) m_en = wd[1:0];
        end
        @(posedge clk);
        #1;
        if (rd) pend = 1;
        evt = '0; bus_wr_en = 0; bus_rd_en = 0;
    endtask

    task automatic rd(input int a, input string tag);
        cyc(5'b0, 0, 1, a, '0, tag);
    endtask
    task automatic wr(input int a, input logic [DW-1:0] d);
        cyc(5'b0, 1, 0, a, d, "");
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(5'b0, 0, 0, 0, '0, "");
    endtask

    // monitor: compares read data one edge after the strobe
    always @(negedge clk) begin
        if (pend) begin
            pend = 0;
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R9: unexpected read data %h expected none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        chk("R1 rdata after reset", bus_rdata, '0);
        chk("R1 irq after reset", DW'(irq), '0);
        rst_n = 1'b1;
        rd(1, "R1 raw after reset");
        rd(0, "R1 enable after reset");

        cyc(5'b00001, 0, 0, 0, '0, "");
        rd(1, "R2 raw after done pulse");
        idle(4);
        rd(1, "R2 flag still set");
        chk("R7 irq low with enable off", DW'(irq), '0);

        wr(0, 32'h1F);
        rd(0, "R5 enable readback drops fault bits");
        chk("R7 irq high when done enabled", DW'(irq), 1);
        rd(2, "R6 masked done");

        cyc(5'b11100, 0, 0, 0, '0, "");
        rd(1, "R2 raw with faults");
        rd(2, "R6 masked hides faults");

        wr(3, 32'h01);
        chk("R7 irq low with only faults set", DW'(irq), 0);
        rd(1, "R3 clear done bit");
        wr(3, 32'h04);
        rd(1, "R3 zero bits untouched");

        cyc(5'b00010, 1, 0, 3, 32'h02, "");
        rd(1, "R4 event wins over clear");
        chk("R4 irq high from result", DW'(irq), 1);

        rd(3, "R9 clear address reads zero");
        rd(5, "R9 unmapped address reads zero");
        rd(1, "R9 raw before hold");
        idle(3);
        chk("R9 rdata holds", bus_rdata, DW'(m_flags));

        wr(4, 32'h0);
        chk("R8 irq low after soft reset", DW'(irq), 0);
        rd(1, "R8 raw after soft reset");
        rd(0, "R8 enable after soft reset");
        cyc(5'b00011, 1, 0, 4, '0, "");
        rd(1, "R8 soft reset beats event");

        wr(0, 32'h02);
        cyc(5'b00001, 0, 0, 0, '0, "");
        chk("R7 disabled done gives no irq", DW'(irq), 0);
        cyc(5'b00010, 0, 0, 0, '0, "");
        chk("R7 enabled result raises irq", DW'(irq), 1);
        rd(2, "R6 masked result only");
        wr(3, 32'h1F);
        chk("R7 irq drops after clear", DW'(irq), 0);
        rd(1, "R3 clear all");

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule